// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block gives two processor ports a small bank of ownership tokens for mutual exclusion over shared resources such as regions of a shared memory. The tokens are single-bit latches that sit apart from any memory array. A token does not guard anything in hardware. Software agrees on what each token stands for, and the block only decides which port holds it.

Each port selects a token by index. To request the token, the port writes a 0 bit with its write strobe. To give it up, the port writes a 1 bit. A read strobe returns one registered status bit one cycle later: 0 means the reading port owns the selected token, and 1 means it does not. Requests are not acknowledged directly, so a port reads back after it requests to learn whether it was granted.

A request against a token that the other port holds is not lost. It stays pending and turns into a grant on the cycle the holder releases. Port 0 has fixed priority when both ports ask for the same free token in one cycle.

Top module: `sem_bank`

## Requirements
- R1: After synchronous reset every token is free: both read data outputs are 1, both read-valid outputs are 0, and a read of any token from either port returns 1.
- R2: A write with data bit 0 to a free token grants it to the writing port. After the grant, that port reads 0 and the other port reads 1 for that token.
- R3: While one port holds a token, a request (data bit 0) from the other port does not take the token. The holder still reads 0 and the requester reads 1.
- R4: A write with data bit 1 from the holder frees the token, and both ports then read 1, unless a request from the other port is waiting or arrives in the same cycle.
- R5: When both ports write data bit 0 to the same free token in the same cycle, port 0 is granted.
- R6: A request that arrives while the token is held is remembered. When the holder releases, the token passes straight to the waiting port, and that port reads 0 with no further write.
- R7: A write with data bit 1 from a port that does not hold the token has no effect on ownership.
- R8: Tokens are independent. A write to one index leaves every other token's state unchanged.
- R9: A read strobe produces read-valid exactly one cycle later. The returned bit reflects ownership before any write accepted in the same cycle as the read.
- R10: A request (data bit 0) from the port that already holds the token leaves it held by that port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| p0_sel | input | SEL_W | Port 0 token index |
| p0_wr | input | 1 | Port 0 write strobe |
| p0_wbit | input | 1 | Port 0 write data: 0 request, 1 release |
| p0_rd | input | 1 | Port 0 read strobe |
| p0_rvalid | output | 1 | Port 0 read data valid, one cycle after p0_rd |
| p0_rbit | output | 1 | Port 0 status: 0 owned by port 0, 1 otherwise |
| p1_sel | input | SEL_W | Port 1 token index |
| p1_wr | input | 1 | Port 1 write strobe |
| p1_wbit | input | 1 | Port 1 write data: 0 request, 1 release |
| p1_rd | input | 1 | Port 1 read strobe |
| p1_rvalid | output | 1 | Port 1 read data valid, one cycle after p1_rd |
| p1_rbit | output | 1 | Port 1 status: 0 owned by port 1, 1 otherwise |

## Verification
The bench builds the block with the default of eight tokens and a 3-bit index. This puts both ends of the index range, 0 and 7, within reach, along with a full sweep of all tokens from both ports to show independence. With eight tokens, same-cycle collisions can be aimed at one index while neighbouring indices are held by the other port, which covers the priority tie, a release meeting a request in the same cycle, and a read in the same cycle as a write.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    TOK_FREE = 2'd0,
    TOK_P0   = 2'd1,
    TOK_P1   = 2'd2
  } tok_owner_e;
endpackage

// File: rtl/sem_token_cell.sv
module sem_token_cell
  import sem_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req0,
  input  logic rel0,
  input  logic req1,
  input  logic rel1,
  output logic own0,
  output logic own1
);
  tok_owner_e owner, owner_n;
  logic pend0, pend1, pend0_n, pend1_n;

  always_comb begin
    owner_n = owner;
    pend0_n = pend0;
    pend1_n = pend1;
    unique case (owner)
      TOK_FREE: begin
        pend0_n = 1'b0;
        pend1_n = 1'b0;
        if (req0) begin
          owner_n = TOK_P0;
          pend1_n = req1;
        end else if (req1) begin
          owner_n = TOK_P1;
        end
      end
      TOK_P0: begin
        pend0_n = 1'b0;
        if (rel0) begin
          pend1_n = 1'b0;
          owner_n = (pend1 || req1) ? TOK_P1 : TOK_FREE;
        end else if (req1) begin
          pend1_n = 1'b1;
        end
      end
      TOK_P1: begin
        pend1_n = 1'b0;
        if (rel1) begin
          pend0_n = 1'b0;
          owner_n = (pend0 || req0) ? TOK_P0 : TOK_FREE;
        end else if (req0) begin
          pend0_n = 1'b1;
        end
      end
      default: begin
        owner_n = TOK_FREE;
        pend0_n = 1'b0;
        pend1_n = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner <= TOK_FREE;
      pend0 <= 1'b0;
      pend1 <= 1'b0;
    end else begin
      owner <= owner_n;
      pend0 <= pend0_n;
      pend1 <= pend1_n;
    end
  end

  assign own0 = (owner == TOK_P0);
  assign own1 = (owner == TOK_P1);

  // R2: a lone request on a free token is granted to the requester
  p_grant_free_r2: assert property (@(posedge clk) disable iff (rst)
    (!own0 && !own1 && req0) |=> own0);
  // R5: tie on a free token goes to port 0
  p_tie_p0_wins_r5: assert property (@(posedge clk) disable iff (rst)
    (!own0 && !own1 && req0 && req1) |=> (own0 && !own1));
  // R3: a held token is not taken by the other port's request
  p_held_kept_r3: assert property (@(posedge clk) disable iff (rst)
    (own0 && !rel0 && req1) |=> own0);
  // R6: a waiting request is granted at the holder's release
  p_handoff_r6: assert property (@(posedge clk) disable iff (rst)
    (own0 && pend1 && rel0) |=> own1);
  // R7: a release from the non-holder changes nothing
  p_foreign_release_r7: assert property (@(posedge clk) disable iff (rst)
    (own1 && rel0 && !rel1) |=> own1);
  // R4: release with nobody waiting frees the token
  p_release_frees_r4: assert property (@(posedge clk) disable iff (rst)
    (own1 && rel1 && !pend0 && !req0) |=> (!own0 && !own1));
  // R8: an untouched token keeps its state
  p_idle_stable_r8: assert property (@(posedge clk) disable iff (rst)
    (!req0 && !rel0 && !req1 && !rel1) |=> ($stable(own0) && $stable(own1)));
  // one holder at most
  p_single_owner_r3: assert property (@(posedge clk) disable iff (rst)
    !(own0 && own1));
endmodule

// File: rtl/sem_read_port.sv
module sem_read_port #(
  parameter int NUM_TOKENS = 8,
  parameter int SEL_W      = (NUM_TOKENS > 1) ? $clog2(NUM_TOKENS) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd,
  input  logic [SEL_W-1:0]      sel,
  input  logic [NUM_TOKENS-1:0] owned,
  output logic                  rvalid,
  output logic                  rbit
);
  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int i = 0; i < NUM_TOKENS; i++) begin
      if (sel == SEL_W'(i)) hit = owned[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvalid <= 1'b0;
      rbit   <= 1'b1;
    end else begin
      rvalid <= rd;
      if (rd) rbit <= ~hit;
    end
  end

  // R9: valid follows the read strobe by exactly one cycle
  p_rvalid_follows_rd_r9: assert property (@(posedge clk) disable iff (rst)
    rd |=> rvalid);
  p_no_spurious_valid_r9: assert property (@(posedge clk) disable iff (rst)
    !rd |=> !rvalid);
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_TOKENS = 8,
  parameter int SEL_W      = (NUM_TOKENS > 1) ? $clog2(NUM_TOKENS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] p0_sel,
  input  logic             p0_wr,
  input  logic             p0_wbit,
  input  logic             p0_rd,
  output logic             p0_rvalid,
  output logic             p0_rbit,
  input  logic [SEL_W-1:0] p1_sel,
  input  logic             p1_wr,
  input  logic             p1_wbit,
  input  logic             p1_rd,
  output logic             p1_rvalid,
  output logic             p1_rbit
);
  logic [NUM_TOKENS-1:0] own0_vec, own1_vec;

  for (genvar g = 0; g < NUM_TOKENS; g++) begin : g_tok
    logic hit0, hit1;
    assign hit0 = p0_wr && (p0_sel == SEL_W'(g));
    assign hit1 = p1_wr && (p1_sel == SEL_W'(g));

    sem_token_cell u_cell (
      .clk  (clk),
      .rst  (rst),
      .req0 (hit0 && !p0_wbit),
      .rel0 (hit0 &&  p0_wbit),
      .req1 (hit1 && !p1_wbit),
      .rel1 (hit1 &&  p1_wbit),
      .own0 (own0_vec[g]),
      .own1 (own1_vec[g])
    );
  end

  sem_read_port #(.NUM_TOKENS(NUM_TOKENS), .SEL_W(SEL_W)) u_rd0 (
    .clk    (clk),
    .rst    (rst),
    .rd     (p0_rd),
    .sel    (p0_sel),
    .owned  (own0_vec),
    .rvalid (p0_rvalid),
    .rbit   (p0_rbit)
  );

  sem_read_port #(.NUM_TOKENS(NUM_TOKENS), .SEL_W(SEL_W)) u_rd1 (
    .clk    (clk),
    .rst    (rst),
    .rd     (p1_rd),
    .sel    (p1_sel),
    .owned  (own1_vec),
    .rvalid (p1_rvalid),
    .rbit   (p1_rbit)
  );

  // R1: reset leaves both read ports idle and reporting not-owned
  p_reset_state_r1: assert property (@(posedge clk)
    $past(rst) |-> (!p0_rvalid && !p1_rvalid && p0_rbit && p1_rbit));
  // R3: the two ports never both hold the same token
  p_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
    (own0_vec & own1_vec) == '0);
endmodule

// File: tb/sim_sem_bank.sv
module sim_sem_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [SW-1:0] p0_sel = '0, p1_sel = '0;
  logic p0_wr = 0, p0_wbit = 0, p0_rd = 0;
  logic p1_wr = 0, p1_wbit = 0, p1_rd = 0;
  logic p0_rvalid, p0_rbit, p1_rvalid, p1_rbit;

  int checks = 0;
  int errors = 0;
  int exp0_q[$], exp1_q[$];
  string tag0_q[$], tag1_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_bank #(.NUM_TOKENS(NT), .SEL_W(SW)) u0 (
    .clk(clk), .rst(rst),
    .p0_sel(p0_sel), .p0_wr(p0_wr), .p0_wbit(p0_wbit), .p0_rd(p0_rd),
    .p0_rvalid(p0_rvalid), .p0_rbit(p0_rbit),
    .p1_sel(p1_sel), .p1_wr(p1_wr), .p1_wbit(p1_wbit), .p1_rd(p1_rd),
    .p1_rvalid(p1_rvalid), .p1_rbit(p1_rbit)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Drive one cycle on both ports; exp < 0 means no read on that port.
  task automatic cyc(input logic aw, input logic ad, input int as, input int aexp,
                     input logic bw, input logic bd, input int bs, input int bexp,
                     input string tag);
    p0_wr = aw; p0_wbit = ad; p0_sel = SW'(as); p0_rd = (aexp >= 0);
    p1_wr = bw; p1_wbit = bd; p1_sel = SW'(bs); p1_rd = (bexp >= 0);
    if (aexp >= 0) begin exp0_q.push_back(aexp); tag0_q.push_back(tag); end
    if (bexp >= 0) begin exp1_q.push_back(bexp); tag1_q.push_back(tag); end
    @(negedge clk);
    p0_wr = 0; p0_rd = 0; p1_wr = 0; p1_rd = 0;
  endtask

  task automatic rd_both(input int s, input int aexp, input int bexp, input string tag);
    cyc(0, 0, s, aexp, 0, 0, s, bexp, tag);
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && p0_rvalid) begin
      if (exp0_q.size() == 0) check("R9 p0 unexpected valid", 1, 0);
      else check(tag0_q.pop_front(), int'(p0_rbit), exp0_q.pop_front());
    end
    if (!rst && p1_rvalid) begin
      if (exp1_q.size() == 0) check("R9 p1 unexpected valid", 1, 0);
      else check(tag1_q.pop_front(), int'(p1_rbit), exp1_q.pop_front());
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    check("watchdog expired", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1: reset outputs
    check("R1 p0_rvalid", int'(p0_rvalid), 0);
    check("R1 p1_rvalid", int'(p1_rvalid), 0);
    check("R1 p0_rbit", int'(p0_rbit), 1);
    check("R1 p1_rbit", int'(p1_rbit), 1);
    for (int i = 0; i < NT; i++) rd_both(i, 1, 1, "R1 all free");

    // R2: port 0 claims token 3
    cyc(1, 0, 3, -1, 0, 0, 0, -1, "R2 req");
    rd_both(3, 0, 1, "R2 grant p0");
    // R3: port 1 requests held token 3
    cyc(0, 0, 0, -1, 1, 0, 3, -1, "R3 req");
    rd_both(3, 0, 1, "R3 held by p0");
    // R10: holder requests again
    cyc(1, 0, 3, -1, 0, 0, 0, -1, "R10 req");
    rd_both(3, 0, 1, "R10 still p0");
    // R7: release from non-holder
    cyc(0, 0, 0, -1, 1, 1, 3, -1, "R7 rel");
    rd_both(3, 0, 1, "R7 no effect");
    // R6: holder releases, pending port 1 gets it
    cyc(1, 1, 3, -1, 0, 0, 0, -1, "R6 rel");
    rd_both(3, 1, 0, "R6 handoff to p1");
    // R4: port 1 releases with nobody waiting
    cyc(0, 0, 0, -1, 1, 1, 3, -1, "R4 rel");
    rd_both(3, 1, 1, "R4 freed");

    // R5: tie on token 7
    cyc(1, 0, 7, -1, 1, 0, 7, -1, "R5 tie");
    rd_both(7, 0, 1, "R5 p0 wins");
    cyc(1, 1, 7, -1, 0, 0, 0, -1, "R6 rel tie");
    rd_both(7, 1, 0, "R6 tie loser granted");
    cyc(0, 0, 0, -1, 1, 1, 7, -1, "R4 rel 7");
    rd_both(7, 1, 1, "R4 token 7 free");

    // R8: hold both ends, others stay free
    cyc(1, 0, 0, -1, 1, 0, 7, -1, "R8 claims");
    rd_both(0, 0, 1, "R8 token 0 p0");
    rd_both(7, 1, 0, "R8 token 7 p1");
    for (int i = 1; i < NT - 1; i++) rd_both(i, 1, 1, "R8 others free");

    // R4: release meeting a same-cycle request passes the token
    cyc(1, 1, 0, -1, 1, 0, 0, -1, "R4 rel+req");
    rd_both(0, 1, 0, "R4 same-cycle pass to p1");

    // R9: read in the same cycle as a request returns prior state
    cyc(1, 0, 5, 1, 0, 0, 5, 1, "R9 read old state");
    rd_both(5, 0, 1, "R9 read new state");

    repeat (4) @(negedge clk);
    check("R9 p0 queue drained", exp0_q.size(), 0);
    check("R9 p1 queue drained", exp1_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule